// File: doc/BRIEF.md
# Clock Update Cycle Sequencer

This block paces the once-per-second update of a real-time clock driven by a 32.768 kHz reference. A prescaler counts reference ticks. A fixed number of ticks before each second rolls over, the block raises an update-in-progress status bit so software knows the time registers are about to become unavailable. At the rollover it issues a one-cycle increment strobe to the time counters. It then holds the registers away from the bus for a fixed number of ticks, and it ends the update with a one-cycle completion event for the interrupt logic.

Software can stop the sequence in two ways: with a set-mode bit, used while it loads a new time, or with a 3-bit divider-control field. Only the code 010 lets the divider run. While the sequence is stopped, the prescaler sits at zero and no status, lockout or strobe is produced. After a release, the first increment comes one full prescaler period later. The calendar arithmetic lives in a neighbouring block.

Top module: `rtc_update_sequencer`

## Requirements
- R1: While reset is asserted (rstN low), uipFlag, busLock, incStrobe and updEnd are all 0.
- R2: With the divider running, incStrobe pulses for one clock cycle on every 2^PRESCALE_BITS-th reference tick, counting from the release of the divider.
- R3: uipFlag goes to 1 after the reference tick that brings the prescaler to 2^PRESCALE_BITS - LEAD_TICKS, which is LEAD_TICKS ticks before the rollover.
- R4: busLock goes to 1 in the same cycle as incStrobe and stays at 1 for exactly UPDATE_TICKS further reference ticks.
- R5: When busLock drops, updEnd pulses for one cycle and uipFlag drops in that same cycle. uipFlag is therefore high for LEAD_TICKS + UPDATE_TICKS ticks.
- R6: busLock is never 1 while uipFlag is 0.
- R7: A clock cycle with refTick at 0 changes neither uipFlag nor busLock, and it produces no strobe. The sequence resumes with no drift when ticks return.
- R8: While setMode is 1, all four outputs are 0 from the next cycle on. An update that is in progress is dropped without an updEnd pulse.
- R9: The divider runs only when divCtl is 3'b010. The reset codes 3'b110 and 3'b111, and every other code, stop the sequence in the same way as setMode.
- R10: After a release from setMode or from a stopping divCtl code, the first incStrobe comes on the 2^PRESCALE_BITS-th tick and not earlier.
- R11: incStrobe and updEnd never stay high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refTick | input | 1 | One-cycle enable for each reference-clock tick |
| setMode | input | 1 | 1 stops updates so the clock can be loaded |
| divCtl | input | 3 | Divider control; 3'b010 runs the divider, other codes stop it |
| uipFlag | output | 1 | Update-in-progress status bit |
| busLock | output | 1 | Time registers are unavailable to the bus |
| incStrobe | output | 1 | One-cycle advance strobe for the time counters |
| updEnd | output | 1 | One-cycle update-finished event |

## Verification
The bound checker checks on every cycle that the outputs relate to each other correctly. Lockout implies the status bit, lockout begins only with an increment, the end event coincides with the fall of both flags, pulses last one cycle, tick-less cycles are inert, and stopping codes clear everything. Only the bench's scenarios can show the absolute tick counts, meaning the lead of the status bit, the length of the lock and the full-period delay after a release. The bench also shows that an interrupted update never reports completion.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  // divider-control code that lets the prescaler run
  localparam logic [2:0] DIV_RUN = 3'b010;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WARN = 2'd1,
    ST_LOCK = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPre;
    logic advPre;
    logic clrLock;
    logic advLock;
  } ctlStrb_t;

endpackage

// File: rtl/rtc_upd_dpath.sv
module rtc_upd_dpath
  import rtc_upd_pkg::*;
#(
  parameter int PRESCALE_BITS = 15,
  parameter int LEAD_TICKS    = 8,
  parameter int UPDATE_TICKS  = 65
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctlStrb_t strb,
  output logic     leadHit,
  output logic     wrapHit,
  output logic     lockLast
);

  localparam int PERIOD = 1 << PRESCALE_BITS;
  localparam int LOCK_W = $clog2(UPDATE_TICKS + 1);
  localparam logic [PRESCALE_BITS-1:0] LEAD_PRE = PRESCALE_BITS'(PERIOD - LEAD_TICKS - 1);
  localparam logic [LOCK_W-1:0] LOCK_END = LOCK_W'(UPDATE_TICKS - 1);

  logic [PRESCALE_BITS-1:0] preCnt;
  logic [LOCK_W-1:0]        lockCnt;

  // prescaler over reference ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preCnt <= '0;
    else if (strb.clrPre) preCnt <= '0;
    else if (strb.advPre) preCnt <= preCnt + 1'b1;
  end

  // ticks elapsed inside the lockout window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lockCnt <= '0;
    else if (strb.clrLock) lockCnt <= '0;
    else if (strb.advLock) lockCnt <= lockCnt + 1'b1;
  end

  // next tick brings the count to the warning point
  assign leadHit  = (preCnt == LEAD_PRE);
  // next tick rolls the prescaler over
  assign wrapHit  = &preCnt;
  // next tick completes the lockout window
  assign lockLast = (lockCnt == LOCK_END);

endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
  import rtc_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       setMode,
  input  logic [2:0] divCtl,
  input  logic       leadHit,
  input  logic       wrapHit,
  input  logic       lockLast,
  output ctlStrb_t   strb,
  output logic       uipFlag,
  output logic       busLock,
  output logic       incStrobe,
  output logic       updEnd
);

  seqState_t state;
  logic      running;

  assign running = !setMode && (divCtl == DIV_RUN);

  always_comb begin
    strb.clrPre  = !running;
    strb.advPre  = running && refTick;
    strb.clrLock = !running || (state != ST_LOCK);
    strb.advLock = running && refTick && (state == ST_LOCK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      incStrobe <= 1'b0;
      updEnd    <= 1'b0;
    end else if (!running) begin
      state     <= ST_IDLE;
      incStrobe <= 1'b0;
      updEnd    <= 1'b0;
    end else begin
      incStrobe <= 1'b0;
      updEnd    <= 1'b0;
      if (refTick) begin
        case (state)
          ST_IDLE: if (leadHit) state <= ST_WARN;
          ST_WARN: if (wrapHit) begin
            state     <= ST_LOCK;
            incStrobe <= 1'b1;
          end
          ST_LOCK: if (lockLast) begin
            state  <= ST_IDLE;
            updEnd <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign uipFlag = (state != ST_IDLE);
  assign busLock = (state == ST_LOCK);

endmodule

// File: rtl/rtc_update_sequencer.sv
module rtc_update_sequencer
  import rtc_upd_pkg::*;
#(
  parameter int PRESCALE_BITS = 15,
  parameter int LEAD_TICKS    = 8,
  parameter int UPDATE_TICKS  = 65
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       setMode,
  input  logic [2:0] divCtl,
  output logic       uipFlag,
  output logic       busLock,
  output logic       incStrobe,
  output logic       updEnd
);
  // LEAD_TICKS + UPDATE_TICKS must stay below 2**PRESCALE_BITS, LEAD_TICKS >= 1

  ctlStrb_t strb;
  logic     leadHit;
  logic     wrapHit;
  logic     lockLast;

  rtc_upd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refTick   (refTick),
    .setMode   (setMode),
    .divCtl    (divCtl),
    .leadHit   (leadHit),
    .wrapHit   (wrapHit),
    .lockLast  (lockLast),
    .strb      (strb),
    .uipFlag   (uipFlag),
    .busLock   (busLock),
    .incStrobe (incStrobe),
    .updEnd    (updEnd)
  );

  rtc_upd_dpath #(
    .PRESCALE_BITS (PRESCALE_BITS),
    .LEAD_TICKS    (LEAD_TICKS),
    .UPDATE_TICKS  (UPDATE_TICKS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .leadHit  (leadHit),
    .wrapHit  (wrapHit),
    .lockLast (lockLast)
  );

endmodule

// File: rtl/rtc_upd_checks.sv
module rtc_upd_checks
  import rtc_upd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       refTick,
  input logic       setMode,
  input logic [2:0] divCtl,
  input logic       uipFlag,
  input logic       busLock,
  input logic       incStrobe,
  input logic       updEnd
);

  logic halted;
  assign halted = setMode || (divCtl != DIV_RUN);

  // R6
  a_r6_lock_implies_uip: assert property (@(posedge clk) disable iff (!rstN)
    busLock |-> uipFlag);

  // R4: lockout opens together with the increment
  a_r4_inc_opens_lock: assert property (@(posedge clk) disable iff (!rstN)
    incStrobe |-> busLock);
  a_r4_lock_rise_with_inc: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busLock) |-> incStrobe);

  // R5: end event marks the fall of both flags
  a_r5_end_clears_flags: assert property (@(posedge clk) disable iff (!rstN)
    updEnd |-> (!busLock && !uipFlag && $past(busLock)));
  a_r5_lock_fall_has_end: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busLock) && !halted && !$past(halted)) |-> updEnd);

  // R3: status bit only rises on a reference tick
  a_r3_uip_rise_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uipFlag) |-> $past(refTick));

  // R7
  a_r7_idle_cycle_inert: assert property (@(posedge clk) disable iff (!rstN)
    (!refTick && !halted) |=> ($stable(uipFlag) && $stable(busLock) && !incStrobe && !updEnd));

  // R8 and R9
  a_r8_r9_halt_clears: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (!uipFlag && !busLock && !incStrobe && !updEnd));

  // R11
  a_r11_inc_single: assert property (@(posedge clk) disable iff (!rstN)
    incStrobe |=> !incStrobe);
  a_r11_end_single: assert property (@(posedge clk) disable iff (!rstN)
    updEnd |=> !updEnd);

endmodule

bind rtc_update_sequencer rtc_upd_checks u_checks (
  .clk       (clk),
  .rstN      (rstN),
  .refTick   (refTick),
  .setMode   (setMode),
  .divCtl    (divCtl),
  .uipFlag   (uipFlag),
  .busLock   (busLock),
  .incStrobe (incStrobe),
  .updEnd    (updEnd)
);

// File: tb/sim_rtc_update_sequencer.sv
`timescale 1ns/1ps
module sim_rtc_update_sequencer;

  localparam int PBITS  = 7;    // period 128 ticks
  localparam int LEAD   = 8;    // warning at tick phase 120
  localparam int UPD    = 20;   // lock ends at phase 20
  localparam int PERIOD = 1 << PBITS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic       setMode = 1'b0;
  logic [2:0] divCtl = 3'b010;
  logic       uipFlag, busLock, incStrobe, updEnd;

  int total = 0;
  int bad = 0;
  int tk = 0;
  int incSeen = 0;
  int endSeen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_update_sequencer #(
    .PRESCALE_BITS (PBITS),
    .LEAD_TICKS    (LEAD),
    .UPDATE_TICKS  (UPD)
  ) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .refTick   (refTick),
    .setMode   (setMode),
    .divCtl    (divCtl),
    .uipFlag   (uipFlag),
    .busLock   (busLock),
    .incStrobe (incStrobe),
    .updEnd    (updEnd)
  );

  always @(negedge clk) begin
    if (incStrobe) incSeen++;
    if (updEnd) endSeen++;
  end

  typedef struct packed {
    int unsigned tick;
    logic uip;
    logic lock;
    logic inc;
    logic fin;
    logic [7:0] req;
  } vec_t;

  // landmarks in ticks since release: tick, uip, lock, inc, end, requirement
  localparam vec_t VECS [12] = '{
    '{119, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},   // R3 not yet warned
    '{120, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3},   // R3 warning raised
    '{127, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3},   // R3 still only warning
    '{128, 1'b1, 1'b1, 1'b1, 1'b0, 8'd2},   // R2 first increment
    '{129, 1'b1, 1'b1, 1'b0, 1'b0, 8'd4},   // R4 lock continues
    '{147, 1'b1, 1'b1, 1'b0, 1'b0, 8'd4},   // R4 last locked tick
    '{148, 1'b0, 1'b0, 1'b0, 1'b1, 8'd5},   // R5 end event
    '{149, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},   // R5 idle again
    '{247, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},   // R3 second second
    '{248, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3},   // R3
    '{256, 1'b1, 1'b1, 1'b1, 1'b0, 8'd2},   // R2 second increment
    '{276, 1'b0, 1'b0, 1'b0, 1'b1, 8'd5}    // R5
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (tick %0d)", tag, what, act, exp, tk);
    end
  endtask

  task automatic chkAll(input string tag, input logic u, input logic l, input logic i, input logic e);
    chk(tag, "uipFlag", int'(uipFlag), int'(u));
    chk(tag, "busLock", int'(busLock), int'(l));
    chk(tag, "incStrobe", int'(incStrobe), int'(i));
    chk(tag, "updEnd", int'(updEnd), int'(e));
  endtask

  // one reference tick followed by one tick-less cycle; ends at a negedge
  task automatic tick();
    @(negedge clk) refTick = 1'b1;
    @(negedge clk) refTick = 1'b0;
    tk++;
  endtask

  task automatic tickTo(input int n);
    while (tk < n) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int incMark;
    int endMark;

    // R1: reset state
    repeat (3) @(negedge clk);
    chkAll("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    tk = 0;

    // landmark table over two seconds
    for (int k = 0; k < 12; k++) begin
      tickTo(int'(VECS[k].tick));
      chkAll($sformatf("R%0d", VECS[k].req), VECS[k].uip, VECS[k].lock, VECS[k].inc, VECS[k].fin);
    end

    // R7: stall inside the lockout, then resume without drift
    tickTo(3 * PERIOD + 5);
    chkAll("R7", 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    chkAll("R7", 1'b1, 1'b1, 1'b0, 1'b0);
    tickTo(3 * PERIOD + UPD - 1);
    chk("R7", "busLock", int'(busLock), 1);
    tickTo(3 * PERIOD + UPD);
    chkAll("R7", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2", "increments so far", incSeen, 3);

    // R8: set mode in the middle of an update
    tickTo(4 * PERIOD + 3);
    chk("R8", "busLock before freeze", int'(busLock), 1);
    incMark = incSeen;
    endMark = endSeen;
    setMode = 1'b1;
    @(negedge clk);
    chkAll("R8", 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2 * PERIOD) tick();
    chkAll("R8", 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "updEnd pulses while frozen", endSeen - endMark, 0);
    chk("R8", "incStrobe pulses while frozen", incSeen - incMark, 0);

    // R10: release from set mode, full period to the first increment
    setMode = 1'b0;
    tk = 0;
    incMark = incSeen;
    tickTo(PERIOD - LEAD - 1);
    chk("R10", "uipFlag", int'(uipFlag), 0);
    tickTo(PERIOD - 1);
    chk("R10", "incStrobe count", incSeen - incMark, 0);
    tickTo(PERIOD);
    chk("R10", "incStrobe", int'(incStrobe), 1);

    // R9: divider reset codes during the warning window
    tickTo(2 * PERIOD - 4);
    chk("R9", "uipFlag before reset code", int'(uipFlag), 1);
    incMark = incSeen;
    endMark = endSeen;
    divCtl = 3'b110;
    @(negedge clk);
    chkAll("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (PERIOD + 10) tick();
    chkAll("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    divCtl = 3'b111;
    repeat (PERIOD + 10) tick();
    chkAll("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    divCtl = 3'b000;
    repeat (PERIOD + 10) tick();
    chkAll("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "pulses while stopped", (incSeen - incMark) + (endSeen - endMark), 0);

    // R10: release from the divider code
    divCtl = 3'b010;
    tk = 0;
    incMark = incSeen;
    tickTo(PERIOD - 1);
    chk("R10", "incStrobe count", incSeen - incMark, 0);
    tickTo(PERIOD);
    chkAll("R10", 1'b1, 1'b1, 1'b1, 1'b0);

    // R11: pulses gone on the following cycle
    @(negedge clk);
    chk("R11", "incStrobe next cycle", int'(incStrobe), 0);
    tickTo(PERIOD + UPD);
    chk("R11", "updEnd", int'(updEnd), 1);
    @(negedge clk);
    chk("R11", "updEnd next cycle", int'(updEnd), 0);

    // R1: reset in the middle of a lock
    tickTo(2 * PERIOD + 2);
    rstN = 1'b0;
    @(negedge clk);
    chkAll("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule